// File: doc/BRIEF.md
# Signed-Digit Binary Adder/Subtractor

This block adds or subtracts two radix-2 numbers held in a redundant form where every digit is -1, 0 or +1. Because a digit set with three values for a radix of two leaves slack in every position, the sum can be formed so that any transfer settles within two positions. The delay through the core is therefore the same for any word length, with no carry chain across the word. The sign of a value lives entirely in its digit values, so there is no separate sign bit and nothing to sign-extend.

Each cycle the block accepts two N-digit operands, an add/subtract select and a valid strobe. It returns an (N+1)-digit result in the same redundant form, registered once, together with its own valid flag. Internally the operands are cleaned and, for subtraction, the second one is negated digit by digit. A first stage then picks a transfer and an interim digit for every position from that position and the one below it. A second stage adds each interim digit to the incoming transfer, and this second add can never overflow.

Top module: `sd_adder_top`

## Requirements
- R1: Digit i of every bus occupies bits [2i+1:2i], the upper bit weighing +1 and the lower bit weighing -1, so 00 is 0, 10 is +1 and 01 is -1; the result never carries code 11 while its valid is high.
- R2: An operand digit coded 11 gives the same result as the same digit coded 00.
- R3: With the subtract select low, the value of the result (sum of digit × 2^i over N+1 digits) equals A + B.
- R4: With the subtract select high, the value of the result equals A - B.
- R5: The result has N+1 digits and the top digit holds the transfer out of digit N-1, so the all-+1 plus all-+1 case gives +1 in the top digit and no value is lost.
- R6: Result digit j depends only on operand digits j, j-1 and j-2: changing operand digit k leaves result digits below k and above k+2 unchanged.
- R7: Output valid goes high exactly one clock after input valid is sampled high, and is low one clock after input valid is sampled low.
- R8: A synchronous active-low reset forces output valid low at the following edge.
- R9: The result register loads only on a clock where input valid is high and keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and select are valid this cycle |
| sub | input | 1 | 0 adds, 1 subtracts the second operand |
| a_dig | input | 2*N | First operand, two bits per digit |
| b_dig | input | 2*N | Second operand, two bits per digit |
| out_valid | output | 1 | Result is valid |
| res_dig | output | 2*(N+1) | Result, two bits per digit |

## Verification
The bench aims at the operand shapes that stress transfer selection: every digit +1, every digit -1 and alternating signs, where a wrong lower-position look-back would leave an interim digit and a transfer of the same sign and produce a wrong value or an illegal 11 code. Full-scale sums check that a design dropping the top digit would lose the final transfer and report a value off by 2^N. Single-digit perturbations check locality, which a design leaking a transfer further than two positions would break. Operands containing code 11 and idle cycles between valid beats check that stray codes are read as zero and that the result register does not move when nothing is presented.

// File: rtl/sd_pkg.sv
// Shared digit encoding for the signed-digit adder.
// Assumes: one digit = two bits {pos, neg}, value pos - neg.
package sd_pkg;
    typedef logic [1:0] sd_code_t;

    localparam sd_code_t SD_ZERO = 2'b00;
    localparam sd_code_t SD_POS  = 2'b10;
    localparam sd_code_t SD_NEG  = 2'b01;

    // Map the unused code onto zero.
    function automatic sd_code_t sd_clean(input sd_code_t c);
        return (c == 2'b11) ? SD_ZERO : c;
    endfunction

    // Negate a digit by exchanging its two bits.
    function automatic sd_code_t sd_flip(input sd_code_t c);
        return {c[0], c[1]};
    endfunction
endpackage

// File: rtl/sd_operand_prep.sv
// Cleans both operands (11 -> 0) and negates the second one when
// subtracting. Purely combinational; assumes N >= 1.
module sd_operand_prep #(
    parameter int N = 8
) (
    input  logic [2*N-1:0] a_raw,
    input  logic [2*N-1:0] b_raw,
    input  logic           sub,
    output logic [2*N-1:0] a_cond,
    output logic [2*N-1:0] b_cond
);
    import sd_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_dig
        // Per-digit clean and optional negate.
        always_comb begin
            a_cond[2*i +: 2] = sd_clean(a_raw[2*i +: 2]);
            b_cond[2*i +: 2] = sub ? sd_flip(sd_clean(b_raw[2*i +: 2]))
                                   : sd_clean(b_raw[2*i +: 2]);
        end
    end
endmodule

// File: rtl/sd_xfer_cell.sv
// Stage one for one digit position: from the two operand digits and a
// flag telling whether neither digit one position lower is negative,
// picks an outgoing transfer and an interim digit. The choice ensures the
// interim digit and the transfer arriving from below never share a sign.
// Assumes clean inputs (no code 11).
module sd_xfer_cell (
    input  logic [1:0] a_d,
    input  logic [1:0] b_d,
    input  logic       low_nonneg,
    output logic [1:0] t_out,
    output logic [1:0] w_out
);
    import sd_pkg::*;

    logic signed [2:0] psum;

    // Position sum in the range -2..+2.
    always_comb begin
        psum = 3'(a_d[1]) + 3'(b_d[1]) - 3'(a_d[0]) - 3'(b_d[0]);
    end

    // Transfer / interim selection.
    always_comb begin
        t_out = SD_ZERO;
        w_out = SD_ZERO;
        case (psum)
            3'sd2: begin
                t_out = SD_POS;
                w_out = SD_ZERO;
            end
            -3'sd2: begin
                t_out = SD_NEG;
                w_out = SD_ZERO;
            end
            3'sd1: begin
                t_out = low_nonneg ? SD_POS : SD_ZERO;
                w_out = low_nonneg ? SD_NEG : SD_POS;
            end
            -3'sd1: begin
                t_out = low_nonneg ? SD_ZERO : SD_NEG;
                w_out = low_nonneg ? SD_NEG  : SD_POS;
            end
            default: begin
                t_out = SD_ZERO;
                w_out = SD_ZERO;
            end
        endcase
    end
endmodule

// File: rtl/sd_sum_cell.sv
// Stage two for one digit position: adds the interim digit to the
// incoming transfer. Assumes they never share a nonzero sign, so the
// result stays a single digit with no further transfer.
module sd_sum_cell (
    input  logic [1:0] w_in,
    input  logic [1:0] t_in,
    output logic [1:0] s_out
);
    import sd_pkg::*;

    // Digit sum without transfer.
    always_comb begin
        if (w_in == SD_ZERO)      s_out = t_in;
        else if (t_in == SD_ZERO) s_out = w_in;
        else                      s_out = SD_ZERO;
    end

    // R1
    always_comb begin
        interim_range_chk: assert (!((w_in == t_in) && (w_in != SD_ZERO)))
            else $error("interim digit and transfer share a sign");
    end
endmodule

// File: rtl/sd_adder_top.sv
// Signed-digit adder/subtractor, constant delay in N. Operands are
// cleaned and conditioned, stage one chooses transfers per digit, stage
// two forms result digits, and the N+1 digit result is registered once.
// Assumes rst_n is synchronous and active low.
module sd_adder_top #(
    parameter int N = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               sub,
    input  logic [2*N-1:0]     a_dig,
    input  logic [2*N-1:0]     b_dig,
    output logic               out_valid,
    output logic [2*(N+1)-1:0] res_dig
);
    import sd_pkg::*;

    localparam int RW = 2 * (N + 1);

    logic [2*N-1:0] a_c;
    logic [2*N-1:0] b_c;
    logic [2*N-1:0] t_vec;   // t_vec[2i+:2] = transfer out of digit i
    logic [2*N-1:0] w_vec;
    logic [N-1:0]   nonneg;  // neither conditioned digit i is negative
    logic [RW-1:0]  sum_c;

    sd_operand_prep #(.N(N)) i_prep (
        .a_raw  (a_dig),
        .b_raw  (b_dig),
        .sub    (sub),
        .a_cond (a_c),
        .b_cond (b_c)
    );

    for (genvar i = 0; i < N; i++) begin : g_pos
        // Sign flag of the digit pair at this position.
        always_comb nonneg[i] = !(a_c[2*i] || b_c[2*i]);

        if (i == 0) begin : g_lsd
            sd_xfer_cell i_xfer (
                .a_d        (a_c[1:0]),
                .b_d        (b_c[1:0]),
                .low_nonneg (1'b1),
                .t_out      (t_vec[1:0]),
                .w_out      (w_vec[1:0])
            );
            sd_sum_cell i_sum (
                .w_in  (w_vec[1:0]),
                .t_in  (SD_ZERO),
                .s_out (sum_c[1:0])
            );
        end else begin : g_upper
            sd_xfer_cell i_xfer (
                .a_d        (a_c[2*i +: 2]),
                .b_d        (b_c[2*i +: 2]),
                .low_nonneg (nonneg[i-1]),
                .t_out      (t_vec[2*i +: 2]),
                .w_out      (w_vec[2*i +: 2])
            );
            sd_sum_cell i_sum (
                .w_in  (w_vec[2*i +: 2]),
                .t_in  (t_vec[2*(i-1) +: 2]),
                .s_out (sum_c[2*i +: 2])
            );
        end
    end

    // Top digit is the last transfer.
    always_comb sum_c[RW-1 -: 2] = t_vec[2*N-1 -: 2];

    // Valid pipeline stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register, loads on valid input only.
    always_ff @(posedge clk) begin
        if (in_valid) res_dig <= sum_c;
    end

    function automatic logic has_bad_code(input logic [RW-1:0] v);
        logic bad;
        bad = 1'b0;
        for (int k = 0; k < N + 1; k++) begin
            if (v[2*k +: 2] == 2'b11) bad = 1'b1;
        end
        return bad;
    endfunction

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !has_bad_code(res_dig));

    // R7
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_dig));
endmodule

// File: tb/test_sd_adder_top.sv
`timescale 1ns/1ps
module test_sd_adder_top;
    localparam int N  = 8;
    localparam int RW = 2 * (N + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           sub = 1'b0;
    logic [2*N-1:0] a_dig = '0;
    logic [2*N-1:0] b_dig = '0;
    logic           out_valid;
    logic [RW-1:0]  res_dig;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sd_adder_top #(.N(N)) i_sd_adder_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sub       (sub),
        .a_dig     (a_dig),
        .b_dig     (b_dig),
        .out_valid (out_valid),
        .res_dig   (res_dig)
    );

    // Integer value of a digit vector (code 11 counts as zero).
    function automatic int sdv(input logic [RW-1:0] v, input int nd);
        int r = 0;
        for (int i = 0; i < nd; i++) begin
            if (v[2*i +: 2] == 2'b10) r += (1 << i);
            else if (v[2*i +: 2] == 2'b01) r -= (1 << i);
        end
        return r;
    endfunction

    function automatic logic [2*N-1:0] rnd_digits();
        logic [2*N-1:0] r;
        for (int i = 0; i < N; i++) begin
            case ($urandom_range(0, 2))
                0: r[2*i +: 2] = 2'b00;
                1: r[2*i +: 2] = 2'b10;
                default: r[2*i +: 2] = 2'b01;
            endcase
        end
        return r;
    endfunction

    function automatic bit any_bad(input logic [RW-1:0] v);
        for (int i = 0; i < N + 1; i++) if (v[2*i +: 2] == 2'b11) return 1;
        return 0;
    endfunction

    // Reference model: one expectation per clock edge.
    typedef struct {
        bit v;
        bit in_rst;
        bit known;
        bit fresh;
        bit sb;
        int val;
    } exp_t;
    exp_t q[$];
    int  m_val = 0;
    bit  m_known = 0;
    bit  m_sub = 0;

    always @(posedge clk) begin
        exp_t e;
        if (in_valid) begin
            m_val   = sub ? sdv({2'b00, a_dig}, N) - sdv({2'b00, b_dig}, N)
                          : sdv({2'b00, a_dig}, N) + sdv({2'b00, b_dig}, N);
            m_sub   = sub;
            m_known = 1;
        end
        e.v      = rst_n && in_valid;
        e.in_rst = !rst_n;
        e.known  = m_known;
        e.fresh  = in_valid;
        e.sb     = m_sub;
        e.val    = m_val;
        q.push_back(e);
    end

    always @(negedge clk) begin
        if (q.size() > 0 && !done) begin
            exp_t e;
            int got;
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v) begin
                failures++;
                $display("FAIL %s out_valid got=%0b exp=%0b",
                         e.in_rst ? "R8" : "R7", out_valid, e.v);
            end
            if (e.known) begin
                got = sdv(res_dig, N + 1);
                checks++;
                if (got != e.val) begin
                    failures++;
                    $display("FAIL %s value got=%0d exp=%0d",
                             !e.fresh ? "R9" : (e.sb ? "R4" : "R3"), got, e.val);
                end
            end
            if (out_valid === 1'b1) begin
                checks++;
                if (any_bad(res_dig)) begin
                    failures++;
                    $display("FAIL R1 illegal code got=%h exp=no 11 digit", res_dig);
                end
            end
        end
    end

    task automatic drive(input logic [2*N-1:0] a, input logic [2*N-1:0] b,
                         input bit s, input bit v);
        @(posedge clk);
        #1;
        a_dig = a;
        b_dig = b;
        sub = s;
        in_valid = v;
    endtask

    task automatic run_one(input logic [2*N-1:0] a, input logic [2*N-1:0] b,
                           input bit s, output logic [RW-1:0] r);
        drive(a, b, s, 1'b1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        r = res_dig;
    endtask

    task automatic expect_eq(input string tag, input logic [RW-1:0] got,
                             input logic [RW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    initial begin
        logic [RW-1:0] r1;
        logic [RW-1:0] r2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3 / R4 / R5 corner patterns
        drive({N{2'b10}}, {N{2'b10}}, 0, 1);
        drive({N{2'b01}}, {N{2'b01}}, 0, 1);
        drive({N{2'b10}}, {N{2'b01}}, 1, 1);
        drive({N{2'b01}}, {N{2'b10}}, 1, 1);
        drive({(N/2){4'b1001}}, {(N/2){4'b0110}}, 0, 1);
        drive({(N/2){4'b1001}}, {(N/2){4'b1001}}, 0, 1);
        drive({(N/2){4'b1001}}, {(N/2){4'b0110}}, 1, 1);
        drive('0, '0, 0, 1);
        drive({N{2'b10}}, '0, 1, 1);

        // R5: top digit carries the final transfer
        run_one({N{2'b10}}, {N{2'b10}}, 0, r1);
        expect_eq("R5 top digit", {{(RW-2){1'b0}}, r1[RW-1 -: 2]}, {{(RW-2){1'b0}}, 2'b10});
        run_one({N{2'b01}}, {N{2'b10}}, 1, r1);
        expect_eq("R5 top digit neg", {{(RW-2){1'b0}}, r1[RW-1 -: 2]}, {{(RW-2){1'b0}}, 2'b01});

        // R2: code 11 behaves as 0
        for (int k = 0; k < N; k++) begin
            logic [2*N-1:0] a;
            logic [2*N-1:0] b;
            logic [2*N-1:0] a11;
            a = rnd_digits();
            b = rnd_digits();
            a[2*k +: 2] = 2'b00;
            a11 = a;
            a11[2*k +: 2] = 2'b11;
            run_one(a, b, k[0], r1);
            run_one(a11, b, k[0], r2);
            expect_eq("R2 code11 on A", r2, r1);
            run_one(b, a11, k[1], r2);
            run_one(b, a, k[1], r1);
            expect_eq("R2 code11 on B", r2, r1);
        end

        // R6: locality of a single digit change
        for (int t = 0; t < 40; t++) begin
            logic [2*N-1:0] a;
            logic [2*N-1:0] b;
            logic [2*N-1:0] a2;
            int k;
            bit s;
            a = rnd_digits();
            b = rnd_digits();
            k = $urandom_range(0, N - 1);
            s = $urandom_range(0, 1);
            a2 = a;
            a2[2*k +: 2] = (a[2*k +: 2] == 2'b10) ? 2'b01 : 2'b10;
            run_one(a, b, s, r1);
            run_one(a2, b, s, r2);
            for (int j = 0; j < N + 1; j++) begin
                if (j < k || j > k + 2)
                    expect_eq("R6 locality", {{(RW-2){1'b0}}, r2[2*j +: 2]},
                              {{(RW-2){1'b0}}, r1[2*j +: 2]});
            end
        end

        // R3 / R4 / R7 / R9 random traffic with gaps
        for (int t = 0; t < 400; t++) begin
            drive(rnd_digits(), rnd_digits(), $urandom_range(0, 1),
                  ($urandom_range(0, 3) != 0));
        end

        // R8: reset mid-stream with valid high
        drive(rnd_digits(), rnd_digits(), 0, 1);
        @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule